// File: doc/BRIEF.md
# First-Come First-Served Bus Arbiter

This block shares one bus among four requesters and hands it out in the order the requests arrived, not by a fixed ranking. Each requester drives an active-low request line and watches its own active-low grant line. A request that comes in while the bus is taken joins the end of a waiting list. When the owner drops its request, the grant moves straight to the requester that has waited longest.

Request lines may change at any time. Each one passes through a two-stage synchronizer, and arrival order is decided from the synchronized values at each rising clock edge. Two or more requests can first appear on the same edge. They then join the list together, in an order set by a free-running pseudo-random register. A common active-low enable can blank every grant without losing the arbitration state.

Top module: `fcfs_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the waiting list is emptied, the synchronizers clear and the tie-break register loads 4'b0001. From the following cycle all `bg_n` bits are high until a new request has been synchronized and listed.
- R2: A lone request on an idle bus is granted from the third rising edge that samples its `req_n` bit low: two synchronizer stages, then one edge to enter the list.
- R3: Bit n of `bg_n` is the grant for bit n of `req_n`, both active low. Requests first seen on different edges are served strictly in the order they were seen.
- R4: When the owner's synchronized request goes inactive, its grant rises in the same cycle that the earliest waiting request's grant falls. An owner whose request stays active is never pre-empted.
- R5: A waiting request that is withdrawn before it is granted leaves the list. The current grant and the order of the other waiters do not change.
- R6: While `en_n` is high, every `bg_n` bit is high. Requests are still listed and released as usual, so the head of the list shows its grant as soon as `en_n` returns low.
- R7: Requests first seen on the same edge join the list on that edge. They are ordered by index, ascending with wrap-around, starting at index (tie register mod 4). The tie register shifts left each cycle out of reset, taking in bit3 XOR bit2 as the new bit0. No grant is shown while the list holds no active request.
- R8: At most one `bg_n` bit is low at any time, and a grant is never low for a request whose synchronized value is inactive.
- R9: A `req_n` bit that is held high is never granted and takes no place in the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbitration clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 4 | Asynchronous bus requests, active low, one per requester |
| en_n | input | 1 | Common grant enable, active low |
| bg_n | output | 4 | Bus grants, active low, bit n for request n |

## Verification
The assertions check the following on every cycle. At most one grant is low. A low grant always matches a synchronized active request. A high enable blanks all grants. Reset leaves the grants idle. An owner that still requests is not displaced. Serving in true arrival order needs a cycle-by-cycle reference model in the bench, and so do the exact three-edge grant latency, the same-cycle handover, removal of a withdrawn waiter, retention of state across a blanked enable, and the tie order that follows the pseudo-random register. The bench's scenarios show these.

// File: rtl/fcfs_arb_pkg.sv
// Package: shared types and the tie-break sequence step for the
// first-come first-served arbiter. Assumes a 4-bit tie register.
package fcfs_arb_pkg;

    localparam int unsigned TIE_W = 4;

    typedef logic [TIE_W-1:0] tie_t;

    // Next state of the tie register: shift left, bit3 ^ bit2 enters at bit0.
    function automatic tie_t tie_step(input tie_t v);
        return {v[TIE_W-2:0], v[TIE_W-1] ^ v[TIE_W-2]};
    endfunction

endpackage

// File: rtl/fcfs_req_sync.sv
// Module: fcfs_req_sync
// Converts active-low asynchronous requests into active-high
// synchronized levels through a chain of STAGES flops per bit.
// Assumes the inputs are otherwise unrelated to clk. Reset clears every
// stage, so no request is seen until STAGES edges after reset.
module fcfs_req_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_n_async,
    output logic [WIDTH-1:0] req_s
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the inverted raw request.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= ~req_n_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages: shift the captured level along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign req_s = stage_q[STAGES-1];

endmodule

// File: rtl/fcfs_tie_lfsr.sv
// Module: fcfs_tie_lfsr
// Free-running pseudo-random register that picks the first index when
// requests arrive together. Assumes the 4-bit step from the package.
// Loads SEED on reset, which makes runs repeatable.
module fcfs_tie_lfsr
    import fcfs_arb_pkg::*;
#(
    parameter tie_t SEED = 4'b0001
) (
    input  logic clk,
    input  logic rst_n,
    output tie_t tie_q
);

    // Advance one step on every cycle outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tie_q <= SEED;
        else        tie_q <= tie_step(tie_q);
    end

endmodule

// File: rtl/fcfs_order_list.sv
// Module: fcfs_order_list
// Holds requester indices in arrival order. In each cycle it removes the
// entries whose synchronized request has dropped (the order of the rest
// is kept) and appends new arrivals in ascending index order, starting
// at start_idx and wrapping. The head of the compacted list is the grant,
// available in the same cycle. Assumes N_REQ >= 2 and that req_s comes
// from synchronizers.
module fcfs_order_list #(
    parameter int unsigned N_REQ = 4,
    localparam int unsigned IDX_W = $clog2(N_REQ),
    localparam int unsigned CNT_W = $clog2(N_REQ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_s,
    input  logic [IDX_W-1:0] start_idx,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx
);

    logic [IDX_W-1:0] slot_q   [N_REQ];
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] kept_idx [N_REQ];
    logic [CNT_W-1:0] kept_cnt;
    logic [IDX_W-1:0] next_idx [N_REQ];
    logic [CNT_W-1:0] next_cnt;
    logic [N_REQ-1:0] listed;
    logic [N_REQ-1:0] arrivals;

    // Mark which requesters hold a list entry.
    always_comb begin
        listed = '0;
        for (int i = 0; i < int'(N_REQ); i++) begin
            if (i < int'(cnt_q)) listed[slot_q[i]] = 1'b1;
        end
    end

    assign arrivals = req_s & ~listed;

    // Compact the list: keep entries whose request is still active, in order.
    always_comb begin
        logic [CNT_W-1:0] k;
        k = '0;
        for (int i = 0; i < int'(N_REQ); i++) kept_idx[i] = '0;
        for (int i = 0; i < int'(N_REQ); i++) begin
            if (i < int'(cnt_q) && req_s[slot_q[i]]) begin
                kept_idx[k[IDX_W-1:0]] = slot_q[i];
                k = k + 1'b1;
            end
        end
        kept_cnt = k;
    end

    // Append the new arrivals after the kept entries, tie order from start_idx.
    always_comb begin
        logic [CNT_W-1:0] k;
        int p;
        k = kept_cnt;
        for (int i = 0; i < int'(N_REQ); i++) next_idx[i] = kept_idx[i];
        for (int j = 0; j < int'(N_REQ); j++) begin
            p = int'(start_idx) + j;
            if (p >= int'(N_REQ)) p = p - int'(N_REQ);
            if (arrivals[IDX_W'(p)]) begin
                next_idx[k[IDX_W-1:0]] = IDX_W'(p);
                k = k + 1'b1;
            end
        end
        next_cnt = k;
    end

    // Store the updated list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < int'(N_REQ); i++) slot_q[i] <= '0;
        end else begin
            cnt_q <= next_cnt;
            for (int i = 0; i < int'(N_REQ); i++) slot_q[i] <= next_idx[i];
        end
    end

    assign grant_valid = (kept_cnt != '0);
    assign grant_idx   = kept_idx[0];

endmodule

// File: rtl/fcfs_arbiter.sv
// Module: fcfs_arbiter (top)
// First-come first-served arbiter with active-low requests, grants and
// enable. Requests are synchronized, ordered by arrival, ties broken by
// the pseudo-random register. Grants are decoded from the list head and
// blanked by en_n. Assumes en_n is synchronous to clk.
module fcfs_arbiter #(
    parameter int unsigned N_REQ       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_n,
    input  logic             en_n,
    output logic [N_REQ-1:0] bg_n
);
    import fcfs_arb_pkg::*;

    localparam int unsigned IDX_W = $clog2(N_REQ);

    logic [N_REQ-1:0] req_s;
    tie_t             tie_q;
    logic [IDX_W-1:0] start_idx;
    logic             grant_valid;
    logic [IDX_W-1:0] grant_idx;

    fcfs_req_sync #(.WIDTH(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_n_async (req_n),
        .req_s       (req_s)
    );

    fcfs_tie_lfsr #(.SEED(4'b0001)) u_tie (
        .clk   (clk),
        .rst_n (rst_n),
        .tie_q (tie_q)
    );

    assign start_idx = IDX_W'(tie_q % N_REQ);

    fcfs_order_list #(.N_REQ(N_REQ)) u_list (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_s       (req_s),
        .start_idx   (start_idx),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    for (genvar n = 0; n < N_REQ; n++) begin : g_grant
        // Grant n is low when n heads the list and the enable is low.
        assign bg_n[n] = ~(grant_valid && (grant_idx == IDX_W'(n)) && !en_n);
    end

endmodule

// File: rtl/fcfs_arbiter_chk.sv
// Module: fcfs_arbiter_chk
// Property checker for fcfs_arbiter, bound to every instance. It reads
// the ports and the synchronized request levels.
module fcfs_arbiter_chk #(
    parameter int unsigned N_REQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_n,
    input logic [N_REQ-1:0] bg_n,
    input logic [N_REQ-1:0] req_s
);

    // R1: a reset edge leaves every grant inactive in the next cycle.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> &bg_n);

    // R8: never more than one grant.
    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bg_n));

    // R6: a high enable blanks all grants.
    a_r6_enable_blank: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> &bg_n);

    for (genvar n = 0; n < N_REQ; n++) begin : g_bit
        // R8: a grant only for a synchronized active request.
        a_r8_grant_live: assert property (@(posedge clk) disable iff (!rst_n)
            !bg_n[n] |-> req_s[n]);

        // R4: an owner that keeps requesting keeps the bus.
        a_r4_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
            (!bg_n[n] && !en_n) |=> (en_n || !req_s[n] || !bg_n[n]));
    end

endmodule

bind fcfs_arbiter fcfs_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_n  (en_n),
    .bg_n  (bg_n),
    .req_s (req_s)
);

// File: tb/test_fcfs_arbiter.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model (queue of indices, integer tie
// register) is compared with the grants on every cycle.
module test_fcfs_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       en_n = 1'b0;
    logic [3:0] bg_n;

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    saw3 = 0;

    always #2 clk = ~clk;

    fcfs_arbiter i_fcfs_arbiter (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (req_n),
        .en_n  (en_n),
        .bg_n  (bg_n)
    );

    // Reference model state.
    int       m_q[$];
    bit [3:0] m_s1, m_s2;
    int       m_tie;

    always @(posedge clk) begin
        int  nq[$];
        int  st;
        int  p;
        bit  present;
        if (!rst_n) begin
            m_q.delete();
            m_s1 = '0;
            m_s2 = '0;
            m_tie = 1;
        end else begin
            nq.delete();
            foreach (m_q[i]) if (m_s2[m_q[i]]) nq.push_back(m_q[i]);
            st = m_tie % 4;
            for (int j = 0; j < 4; j++) begin
                p = (st + j) % 4;
                present = 0;
                foreach (m_q[i]) if (m_q[i] == p) present = 1;
                if (m_s2[p] && !present) nq.push_back(p);
            end
            m_q = nq;
            m_tie = ((m_tie << 1) & 15) | (((m_tie >> 3) ^ (m_tie >> 2)) & 1);
            m_s2 = m_s1;
            m_s1 = ~req_n;
        end
    end

    function automatic logic [3:0] expect_bg();
        int g = -1;
        foreach (m_q[i]) begin
            if (m_s2[m_q[i]]) begin
                g = m_q[i];
                break;
            end
        end
        if (en_n || g < 0) return 4'hF;
        return ~(4'b0001 << g);
    endfunction

    task automatic compare();
        logic [3:0] e;
        e = expect_bg();
        checks++;
        if (bg_n[3] == 1'b0) saw3 = 1;
        if (bg_n !== e) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, bg_n, e);
        end
    endtask

    task automatic cyc(input logic [3:0] r, input logic e, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            req_n = r;
            en_n  = e;
        end
    endtask

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, with a request already low during reset.
        tag = "R1";
        cyc(4'b1110, 1'b0, 4);
        @(negedge clk);
        compare();
        req_n = 4'hF;
        rst_n = 1'b1;
        cyc(4'hF, 1'b0, 4);

        // R2: lone request on an idle bus, three-edge latency.
        tag = "R2";
        cyc(4'b1011, 1'b0, 6);

        // R3: requests 1, 3, 0 queue behind owner 2.
        tag = "R3";
        cyc(4'b1001, 1'b0, 3);
        cyc(4'b0001, 1'b0, 3);
        cyc(4'b0000, 1'b0, 4);

        // R4: owner 2 releases -> 1; owner 1 releases -> 3.
        tag = "R4";
        cyc(4'b0100, 1'b0, 5);
        cyc(4'b0110, 1'b0, 5);

        // R5: queue 1 and 2 behind 3, 0; withdraw 1; then drain.
        tag = "R5";
        cyc(4'b0000, 1'b0, 4);
        cyc(4'b0010, 1'b0, 4);
        cyc(4'b1010, 1'b0, 5);
        cyc(4'b1011, 1'b0, 5);

        // R6: blank the grant, list 0 meanwhile, reenable.
        tag = "R6";
        cyc(4'b1011, 1'b1, 4);
        cyc(4'b1010, 1'b1, 4);
        cyc(4'b1010, 1'b0, 4);
        cyc(4'b1110, 1'b0, 5);
        cyc(4'hF, 1'b0, 5);

        // R7 R8: simultaneous arrivals under varying tie register states.
        tag = "R7 R8";
        for (int k = 0; k < 6; k++) begin
            cyc(4'b0000, 1'b0, 5 + k);
            cyc(4'hF, 1'b0, 5);
            cyc(4'b1100, 1'b0, 4 + k);
            cyc(4'b1110, 1'b0, 4);
            cyc(4'hF, 1'b0, 4);
        end
        // Tie behind an owner, then staggered releases.
        cyc(4'b0111, 1'b0, 5);
        cyc(4'b0100, 1'b0, 5);
        cyc(4'b1100, 1'b0, 5);
        cyc(4'b1101, 1'b0, 5);
        cyc(4'hF, 1'b0, 5);

        // R9: request 3 held high while the others churn.
        tag = "R9";
        saw3 = 0;
        for (int p = 0; p < 16; p++) begin
            cyc({1'b1, 3'(p * 5 + 3)}, 1'b0, 4);
        end
        cyc(4'hF, 1'b0, 5);
        checks++;
        if (saw3) begin
            failures++;
            $display("FAIL R9 actual=granted3 expected=never");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule